// File: doc/BRIEF.md
# Local Processor Timer with Prescaler

This block is a timer private to one processor core. A 32-bit down-counter is decremented on ticks from a power-of-two prescaler running off the bus clock, so the decrement interval can be 1, 2, 4 and so on up to 128 bus clocks. When the count runs out, the block raises an interrupt request on a single output wired only to the owning core. No shared interrupt line is used.

Software programs a divide setting, a one-shot or periodic mode and a mask bit through one configuration write strobe. It starts the timer by writing an initial count. In one-shot mode the counter stops at zero. In periodic mode the tick that would bring the count to zero loads the initial count again instead, so the interrupt period is exactly the initial count times the divide ratio. The current count is always visible on an output port. The pending request stays high until the core acknowledges it.

Top module: `lt_local_timer`

## Requirements
- R1: After reset the current count is 0, the interrupt output is low, the divide field is 0, the mode is one-shot and the mask is clear.
- R2: A pulse on `init_we` stores `init_wdata` as the initial count and places it on `cur_count` in the next cycle. It also clears the prescaler.
- R3: A divide field value n on `cfg_div` (0 to 7) makes the counter decrement once every 2^n bus clocks. When an initial count V is written at clock edge E, the count runs out at edge E + V*2^n.
- R4: In one-shot mode (`cfg_periodic` = 0), the count reaches 0, stays at 0 and raises the request once.
- R5: In periodic mode (`cfg_periodic` = 1), the tick that would bring the count to 0 loads the initial count instead and raises the request. Expiries follow one another every V*2^n bus clocks.
- R6: Writing an initial count of 0 stops the timer. The count reads 0 and no request is raised.
- R7: With `cfg_mask` = 1, `irq` stays low while the counter keeps running. A request raised while masked is held, and `irq` goes high as soon as the mask is cleared.
- R8: `irq_ack` clears the pending request at the next edge. An expiry in the same cycle takes priority, so the request stays set.
- R9: Writing a new initial count while the timer runs restarts the countdown from the new value.
- R10: A configuration write does not change the current count. The count only moves on prescaler ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_we | input | 1 | Write strobe for the initial count |
| init_wdata | input | 32 | Initial count value |
| cfg_we | input | 1 | Write strobe for divide, mode and mask |
| cfg_div | input | 3 | Divide exponent n; the divide ratio is 2^n |
| cfg_periodic | input | 1 | 1 selects periodic mode, 0 selects one-shot |
| cfg_mask | input | 1 | 1 hides the interrupt request |
| irq_ack | input | 1 | Acknowledge that clears the pending request |
| cur_count | output | 32 | Current counter value |
| irq | output | 1 | Interrupt request to the owning core |

## Verification
A wrong prescaler phase or counter value moves the edge on which `irq` rises. The bench therefore samples `irq` one cycle before and at the exact expected edge V*2^n after the load, so an error of a single cycle shows up. A periodic reload with the wrong value shows in the second period, which the bench also times, and in `cur_count` at the moment of expiry. A lost or mis-set pending bit shows on `irq` within one cycle of an acknowledge or of clearing the mask.

// File: rtl/lt_pkg.sv
package lt_pkg;
    localparam int DIV_W = 3;

    typedef enum logic {
        LT_ONESHOT  = 1'b0,
        LT_PERIODIC = 1'b1
    } lt_mode_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        lt_mode_e         mode;
        logic             mask;
    } lt_cfg_t;
endpackage

// File: rtl/lt_prescaler.sv
module lt_prescaler #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int PRE_W = (1 << DIV_W) - 1;

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] sel;

    always_comb begin
        sel   = PRE_W'((1 << div) - 1);
        tick  = run && ((pre_q & sel) == sel);
        pre_d = pre_q + PRE_W'(1);
        if (clear || !run) pre_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/lt_countdown.sv
module lt_countdown #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             periodic,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
    } cd_state_t;

    cd_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (load) begin
            st_d.cnt = load_val;
            st_d.run = (load_val != '0);
        end else if (tick && st_q.run) begin
            if (st_q.cnt == CNT_W'(1)) begin
                expire = 1'b1;
                if (periodic) begin
                    st_d.cnt = reload_val;
                end else begin
                    st_d.cnt = '0;
                    st_d.run = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count   = st_q.cnt;
    assign running = st_q.run;
endmodule

// File: rtl/lt_local_timer.sv
module lt_local_timer #(
    parameter int CNT_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    init_we,
    input  logic [CNT_W-1:0]        init_wdata,
    input  logic                    cfg_we,
    input  logic [lt_pkg::DIV_W-1:0] cfg_div,
    input  logic                    cfg_periodic,
    input  logic                    cfg_mask,
    input  logic                    irq_ack,
    output logic [CNT_W-1:0]        cur_count,
    output logic                    irq
);
    import lt_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] init;
        lt_cfg_t          cfg;
        logic             pend;
    } top_state_t;

    top_state_t st_d, st_q;

    logic             tick_w;
    logic             expire_w;
    logic             running_w;
    logic             mask_w;
    logic [DIV_W-1:0] div_w;
    logic             periodic_w;

    assign mask_w     = st_q.cfg.mask;
    assign div_w      = st_q.cfg.div;
    assign periodic_w = (st_q.cfg.mode == LT_PERIODIC);

    lt_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (init_we),
        .run   (running_w),
        .div   (div_w),
        .tick  (tick_w)
    );

    lt_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (init_we),
        .load_val   (init_wdata),
        .tick       (tick_w),
        .periodic   (periodic_w),
        .reload_val (st_q.init),
        .count      (cur_count),
        .running    (running_w),
        .expire     (expire_w)
    );

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            st_d.cfg.div  = cfg_div;
            st_d.cfg.mode = cfg_periodic ? LT_PERIODIC : LT_ONESHOT;
            st_d.cfg.mask = cfg_mask;
        end
        if (init_we)  st_d.init = init_wdata;
        if (irq_ack)  st_d.pend = 1'b0;
        if (expire_w) st_d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.pend && !st_q.cfg.mask;
endmodule

// File: rtl/lt_local_timer_chk.sv
module lt_local_timer_chk #(
    parameter int CNT_W = 32,
    parameter int DIV_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             init_we,
    input logic [CNT_W-1:0] init_wdata,
    input logic             cfg_we,
    input logic             irq_ack,
    input logic             mask,
    input logic [DIV_W-1:0] div,
    input logic             tick,
    input logic             expire,
    input logic             running,
    input logic [CNT_W-1:0] cur_count,
    input logic             irq
);
    // R2
    load_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_we |=> cur_count == $past(init_wdata));

    // R3
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0 && !init_we && !cfg_we) |=> !tick);

    // R3
    decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && running && cur_count > CNT_W'(1) && !init_we)
        |=> cur_count == $past(cur_count) - CNT_W'(1));

    // R4
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_count == '0 && !init_we) |=> cur_count == '0);

    // R8
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !expire) |=> !irq);

    // R8
    expire_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !mask && !cfg_we) |=> irq);

    // R10
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !init_we) |=> $stable(cur_count));
endmodule

bind lt_local_timer lt_local_timer_chk #(.CNT_W(CNT_W), .DIV_W(lt_pkg::DIV_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_we    (init_we),
    .init_wdata (init_wdata),
    .cfg_we     (cfg_we),
    .irq_ack    (irq_ack),
    .mask       (mask_w),
    .div        (div_w),
    .tick       (tick_w),
    .expire     (expire_w),
    .running    (running_w),
    .cur_count  (cur_count),
    .irq        (irq)
);

// File: tb/lt_local_timer_tb.sv
module lt_local_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_we = 1'b0;
    logic [31:0] init_wdata = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_div = '0;
    logic        cfg_periodic = 1'b0;
    logic        cfg_mask = 1'b0;
    logic        irq_ack = 1'b0;
    logic [31:0] cur_count;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    lt_local_timer u_dut (
        .clk(clk), .rst_n(rst_n), .init_we(init_we), .init_wdata(init_wdata),
        .cfg_we(cfg_we), .cfg_div(cfg_div), .cfg_periodic(cfg_periodic),
        .cfg_mask(cfg_mask), .irq_ack(irq_ack), .cur_count(cur_count), .irq(irq)
    );

    // vector: {div[2:0], periodic, init[31:0]}
    localparam logic [35:0] VEC [7] = '{
        {3'd0, 1'b0, 32'd5}, {3'd1, 1'b0, 32'd4}, {3'd3, 1'b0, 32'd3},
        {3'd7, 1'b0, 32'd2}, {3'd2, 1'b1, 32'd6}, {3'd0, 1'b1, 32'd3},
        {3'd5, 1'b1, 32'd2}
    };

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [2:0] d, input logic p, input logic m);
        cfg_we = 1'b1; cfg_div = d; cfg_periodic = p; cfg_mask = m;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_init(input logic [31:0] v);
        init_we = 1'b1; init_wdata = v;
        @(negedge clk);
        init_we = 1'b0;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cur_count == 0, "R1 count", cur_count, 0);
        chk(irq == 0, "R1 irq", irq, 0);

        for (int i = 0; i < 7; i++) begin
            logic [2:0]  d;
            logic        p;
            logic [31:0] v;
            int          tot;
            {d, p, v} = VEC[i];
            tot = int'(v) << d;
            wr_cfg(d, p, 1'b0);
            wr_init(v);
            chk(cur_count == v, "R2 load", cur_count, v);
            repeat (tot - 1) @(negedge clk);
            chk(irq == 0, "R3 early", irq, 0);
            @(negedge clk);
            chk(irq == 1, "R3 expiry edge", irq, 1);
            if (p) begin
                chk(cur_count == v, "R5 reload", cur_count, v);
                ack();
                chk(irq == 0, "R8 ack", irq, 0);
                repeat (tot - 2) @(negedge clk);
                chk(irq == 0, "R5 second early", irq, 0);
                @(negedge clk);
                chk(irq == 1, "R5 second expiry", irq, 1);
                ack();
                wr_init(32'd0);
            end else begin
                chk(cur_count == 0, "R4 at zero", cur_count, 0);
                ack();
                chk(irq == 0, "R8 ack", irq, 0);
                repeat (20) @(negedge clk);
                chk(cur_count == 0 && irq == 0, "R4 stays zero", {cur_count, 31'd0, irq}, 0);
            end
        end

        // R7 masked expiry held, then shown on unmask
        wr_cfg(3'd0, 1'b0, 1'b1);
        wr_init(32'd4);
        repeat (4) @(negedge clk);
        chk(irq == 0, "R7 masked", irq, 0);
        chk(cur_count == 0, "R7 counter ran", cur_count, 0);
        wr_cfg(3'd0, 1'b0, 1'b0);
        chk(irq == 1, "R7 unmask shows", irq, 1);
        ack();

        // R6 write zero stops
        wr_init(32'd100);
        repeat (5) @(negedge clk);
        wr_init(32'd0);
        chk(cur_count == 0, "R6 stopped", cur_count, 0);
        repeat (150) @(negedge clk);
        chk(irq == 0 && cur_count == 0, "R6 no irq", {cur_count, 31'd0, irq}, 0);

        // R9 restart mid-run
        wr_init(32'd50);
        repeat (9) @(negedge clk);
        wr_init(32'd20);
        chk(cur_count == 20, "R9 reload", cur_count, 20);
        repeat (19) @(negedge clk);
        chk(irq == 0, "R9 early", irq, 0);
        @(negedge clk);
        chk(irq == 1, "R9 expiry", irq, 1);
        ack();

        // R10 config write leaves count alone
        wr_init(32'd30);
        repeat (5) @(negedge clk);
        chk(cur_count == 25, "R10 before", cur_count, 25);
        wr_cfg(3'd0, 1'b0, 1'b1);
        chk(cur_count == 24, "R10 after cfg", cur_count, 24);
        wr_init(32'd0);
        wr_cfg(3'd0, 1'b0, 1'b0);
        ack();

        // R8 expiry beats acknowledge
        wr_cfg(3'd0, 1'b1, 1'b0);
        wr_init(32'd1);
        @(negedge clk);
        irq_ack = 1'b1;
        repeat (3) @(negedge clk);
        chk(irq == 1, "R8 expiry wins", irq, 1);
        irq_ack = 1'b0;
        wr_init(32'd0);
        ack();
        chk(irq == 0, "R8 final clear", irq, 0);

        finish_run();
    end
endmodule